// File: doc/BRIEF.md
# Oversampled legacy-bus read sequencer

This block is the host side of a legacy 8/16-bit expansion bus, reduced to read cycles only: memory reads and I/O reads. A requester raises a one-cycle request carrying an address, a memory/I/O select and a narrow (8-bit) flag. The block then runs the whole bus cycle and answers with a one-cycle acknowledge together with the read data.

The sequencer runs from a clock several times faster than the bus rate, so every bus-side edge lands on a fast tick. The address is presented for a set number of ticks before the active-low strobe falls. The strobe is then held low for a minimum number of ticks. A slow peripheral can pull the ready line low early in the strobe to stretch it without limit. The ready line is asynchronous and passes through a two-stage synchroniser. The read data is registered on the same edge that releases the strobe, so the peripheral needs no hold time. An optional watchdog on the ready line abandons a cycle that stalls for too long, releases the strobe and reports an error.

Top module: `isa_read_ctrl`

## Requirements
- R1: While reset is asserted, both strobes are high (inactive), `ack` and `err` are 0 and the bus address is 0.
- R2: A request accepted on edge k drives its address from edge k. The strobe falls on edge k+SETUP_TICKS. The address stays unchanged through the acknowledge cycle, which is the first tick after the strobe rises.
- R3: When `req_io`=1 only `bus_ior_n` goes low. When `req_io`=0 only `bus_memr_n` goes low. The two strobes are never low together.
- R4: Without a wait, the strobe stays low for exactly END = max(STROBE_TICKS, READY_WIN+2) ticks (6 with the defaults).
- R5: Ready first seen low at strobe tick a < READY_WIN and high again at tick b stretches the strobe to max(b+4+POST_READY, END) ticks. Tick 0 is the first tick the strobe is low. Ready going low at a tick a ≥ READY_WIN has no effect on the width.
- R6: `rd_data` shows the bus data present on the edge that releases the strobe. A change of the bus data after that edge does not alter it.
- R7: With `req_byte`=1, `rd_data[15:8]` is 0 and `rd_data[7:0]` is bus data bits 7:0.
- R8: `ack` is high for exactly one cycle per cycle run. That cycle is the first one in which the strobe is high again.
- R9: With a request held high, the next strobe falls RECOVER_TICKS+2+SETUP_TICKS ticks after the acknowledge cycle.
- R10: A request raised while a cycle is in progress is ignored: no extra cycle runs and the address does not change.
- R11: If ready stays low for more than TIMEOUT_TICKS ticks after the wait is entered (b−a > TIMEOUT_TICKS), the strobe is released after a+3+TIMEOUT_TICKS ticks. `ack` and `err` are then raised together and `rd_data` is 0. At b−a = TIMEOUT_TICKS the cycle completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle read request, taken only when idle |
| req_addr | input | ADDR_W | Address of the read |
| req_io | input | 1 | 1 = I/O read, 0 = memory read |
| req_byte | input | 1 | 1 = 8-bit read, zero-extended |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `ack` when the cycle was abandoned |
| rd_data | output | DATA_W | Read data, valid with `ack` |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_memr_n | output | 1 | Active-low memory read strobe |
| bus_ior_n | output | 1 | Active-low I/O read strobe |
| bus_rdy | input | 1 | Asynchronous ready from the peripheral, low = stretch |
| bus_data | input | DATA_W | Bus data lines |

## Verification
The ready line is swept over every start tick from inside to just outside the sampling window, with every release tick up to six ticks later. Start ticks inside the window tell a real stretch apart from one that is wrongly ignored, and those just outside tell apart a window that is too wide. Two long stalls sit one tick either side of the watchdog limit, which pins down the comparison that triggers the abort. Memory/I/O select and the narrow flag alternate across the sweep. The bus data is changed on the acknowledge tick, so a late capture shows up. Separate runs cover a request raised mid-cycle and a request held high across back-to-back cycles.

// File: rtl/isa_rd_pkg.sv
package isa_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_STROBE,
        ST_WAIT_READY,
        ST_CAPTURE,
        ST_RECOVER
    } seq_state_e;

endpackage

// File: rtl/isa_rd_sync.sv
module isa_rd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/isa_rd_fmt.sv
module isa_rd_fmt #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              narrow,
    output logic [DATA_W-1:0] shaped
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_low
            assign shaped[i] = raw[i];
        end else begin : g_high
            assign shaped[i] = raw[i] & ~narrow;
        end
    end

endmodule

// File: rtl/isa_rd_seq.sv
module isa_rd_seq
    import isa_rd_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int SETUP_TICKS   = 2,
    parameter int STROBE_TICKS  = 5,
    parameter int READY_WIN     = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int POST_READY    = 2,
    parameter int RECOVER_TICKS = 2,
    parameter int TIMEOUT_TICKS = 40,
    parameter int TIMEOUT_EN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_byte,
    input  logic              rdy_s,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic              strobe_o,
    output logic              io_o,
    output logic              narrow_o,
    output logic              ack_o,
    output logic              err_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int WIN_END = READY_WIN + SYNC_STAGES;
    localparam int END_T   = (STROBE_TICKS > WIN_END) ? STROBE_TICKS : WIN_END;
    localparam int MAX_A   = (SETUP_TICKS > RECOVER_TICKS) ? SETUP_TICKS : RECOVER_TICKS;
    localparam int MAX_C   = (MAX_A > END_T) ? MAX_A : END_T;
    localparam int CNT_W   = $clog2(MAX_C + 1);
    localparam int TMO_W   = $clog2(TIMEOUT_TICKS + 1);
    localparam int HOLD_W  = $clog2(POST_READY + 2);
    localparam int WID_W   = CNT_W + 2;

    localparam logic [CNT_W-1:0]  C_SETUP_LAST = CNT_W'(SETUP_TICKS - 1);
    localparam logic [CNT_W-1:0]  C_END        = CNT_W'(END_T);
    localparam logic [CNT_W-1:0]  C_LAST       = CNT_W'(END_T - 1);
    localparam logic [CNT_W-1:0]  C_WIN        = CNT_W'(WIN_END);
    localparam logic [CNT_W-1:0]  C_REC_LAST   = CNT_W'(RECOVER_TICKS - 1);
    localparam logic [TMO_W-1:0]  C_TMO_LAST   = TMO_W'(TIMEOUT_TICKS - 1);
    localparam logic [HOLD_W-1:0] C_POST       = HOLD_W'(POST_READY);
    localparam logic [WID_W-1:0]  C_MIN_WIDTH  = WID_W'(END_T);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [TMO_W-1:0]  tmo;
        logic [HOLD_W-1:0] hold;
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic              narrow;
        logic              strobe;
        logic              err;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] cnt_sat;

    always_comb begin
        cnt_sat = (r_q.cnt == C_END) ? r_q.cnt : r_q.cnt + 1'b1;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state  = ST_ADDR_SETUP;
                    r_d.addr   = req_addr;
                    r_d.io     = req_io;
                    r_d.narrow = req_byte;
                    r_d.cnt    = '0;
                    r_d.err    = 1'b0;
                end
            end
            ST_ADDR_SETUP: begin
                if (r_q.cnt == C_SETUP_LAST) begin
                    r_d.state  = ST_STROBE;
                    r_d.strobe = 1'b1;
                    r_d.cnt    = '0;
                    r_d.hold   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STROBE: begin
                r_d.cnt = cnt_sat;
                if (!rdy_s && (r_q.cnt < C_WIN)) begin
                    r_d.state = ST_WAIT_READY;
                    r_d.tmo   = '0;
                end else if (r_q.hold != '0) begin
                    r_d.hold = r_q.hold - 1'b1;
                end else if (r_q.cnt >= C_LAST) begin
                    r_d.state  = ST_CAPTURE;
                    r_d.strobe = 1'b0;
                    r_d.data   = data_in;
                end
            end
            ST_WAIT_READY: begin
                r_d.cnt = cnt_sat;
                if (rdy_s) begin
                    r_d.state = ST_STROBE;
                    r_d.hold  = C_POST;
                end else if ((TIMEOUT_EN != 0) && (r_q.tmo == C_TMO_LAST)) begin
                    r_d.state  = ST_CAPTURE;
                    r_d.strobe = 1'b0;
                    r_d.err    = 1'b1;
                    r_d.data   = '0;
                end else if (r_q.tmo != C_TMO_LAST) begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            ST_CAPTURE: begin
                r_d.state = ST_RECOVER;
                r_d.cnt   = '0;
            end
            ST_RECOVER: begin
                if (r_q.cnt == C_REC_LAST) r_d.state = ST_IDLE;
                else                       r_d.cnt   = r_q.cnt + 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign addr_o   = r_q.addr;
    assign strobe_o = r_q.strobe;
    assign io_o     = r_q.io;
    assign narrow_o = r_q.narrow;
    assign ack_o    = (r_q.state == ST_CAPTURE);
    assign err_o    = (r_q.state == ST_CAPTURE) && r_q.err;
    assign data_o   = r_q.data;

    // Strobe-width monitor feeding the minimum-width check.
    logic [WID_W-1:0] width_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       width_q <= '0;
        else if (r_q.state == ST_ADDR_SETUP) width_q <= '0;
        else if (r_q.strobe && (width_q != '1)) width_q <= width_q + 1'b1;
    end

    assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !err_o) |-> (width_q >= C_MIN_WIDTH));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o || ack_o) |-> $stable(addr_o));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_ack_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(strobe_o) && !strobe_o));

    assert_err_with_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ack_o && (data_o == '0)));

endmodule

// File: rtl/isa_read_ctrl.sv
module isa_read_ctrl #(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int NARROW_W      = 8,
    parameter int SETUP_TICKS   = 2,
    parameter int STROBE_TICKS  = 5,
    parameter int READY_WIN     = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int POST_READY    = 2,
    parameter int RECOVER_TICKS = 2,
    parameter int TIMEOUT_TICKS = 40,
    parameter int TIMEOUT_EN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_byte,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_memr_n,
    output logic              bus_ior_n,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_data
);

    logic              rdy_s;
    logic              strobe;
    logic              io_sel;
    logic              narrow;
    logic [DATA_W-1:0] shaped;

    isa_rd_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(bus_rdy),
        .sync_out(rdy_s)
    );

    isa_rd_fmt #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) u_fmt (
        .raw   (bus_data),
        .narrow(narrow),
        .shaped(shaped)
    );

    isa_rd_seq #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SETUP_TICKS  (SETUP_TICKS),
        .STROBE_TICKS (STROBE_TICKS),
        .READY_WIN    (READY_WIN),
        .SYNC_STAGES  (SYNC_STAGES),
        .POST_READY   (POST_READY),
        .RECOVER_TICKS(RECOVER_TICKS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .TIMEOUT_EN   (TIMEOUT_EN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_io   (req_io),
        .req_byte (req_byte),
        .rdy_s    (rdy_s),
        .data_in  (shaped),
        .addr_o   (bus_addr),
        .strobe_o (strobe),
        .io_o     (io_sel),
        .narrow_o (narrow),
        .ack_o    (ack),
        .err_o    (err),
        .data_o   (rd_data)
    );

    assign bus_memr_n = ~(strobe & ~io_sel);
    assign bus_ior_n  = ~(strobe & io_sel);

    assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && narrow) |-> (rd_data[DATA_W-1:NARROW_W] == '0));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_memr_n |=> bus_ior_n);

endmodule

// File: tb/isa_read_ctrl_test.sv
`timescale 1ns/1ps
module isa_read_ctrl_test;

    localparam int SETUP = 2;
    localparam int STRB  = 5;
    localparam int WIN   = 4;
    localparam int SYNC  = 2;
    localparam int POST  = 2;
    localparam int REC   = 2;
    localparam int TMO   = 40;
    localparam int ENDT  = (STRB > WIN + SYNC) ? STRB : WIN + SYNC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        req_byte = 1'b0;
    logic        ack, err;
    logic [15:0] rd_data;
    logic [19:0] bus_addr;
    logic        bus_memr_n, bus_ior_n;
    logic        bus_rdy = 1'b1;
    logic [15:0] bus_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    isa_read_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_io(req_io), .req_byte(req_byte), .ack(ack), .err(err),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_memr_n(bus_memr_n),
        .bus_ior_n(bus_ior_n), .bus_rdy(bus_rdy), .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [19:0] addr, input logic io, input logic nb,
                             input logic [15:0] pat, input int a, input int b, input bit poke);
        int n = 0, fall_n = -1, ack_n = -1, w, ack_cnt = 0;
        bit addr_ok = 1, sel_ok = 1, extra = 0, strobe_at_ack = 0, e;
        bit slow;
        logic [15:0] got = '0, expd;
        logic got_err = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_io = io; req_byte = nb;
        bus_data = pat; bus_rdy = 1'b1;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (poke && n == 4) begin req_valid = 1'b1; req_addr = ~addr; req_io = ~io; end
            if (poke && n == 5) req_valid = 1'b0;
            slow = !bus_memr_n || !bus_ior_n;
            if (bus_addr != addr) addr_ok = 0;
            if (slow) sel_ok &= io ? (bus_memr_n && !bus_ior_n) : (!bus_memr_n && bus_ior_n);
            if (slow && ack_n >= 0) extra = 1;
            if (slow && fall_n < 0) fall_n = n;
            if (fall_n >= 0) begin
                if (n - fall_n == a) bus_rdy = 1'b0;
                if (n - fall_n == b) bus_rdy = 1'b1;
            end
            if (ack) begin
                ack_cnt++;
                if (ack_n < 0) begin
                    ack_n = n; got = rd_data; got_err = err; strobe_at_ack = slow;
                    bus_data = ~pat;
                end
            end
            if (ack_n >= 0 && n >= ack_n + REC + 6 && (fall_n < 0 || n - fall_n > b)) break;
            if (n > 600) break;
        end
        bus_rdy = 1'b1;
        if (a >= 0 && a < WIN) begin
            if (b - a > TMO) begin w = a + SYNC + 1 + TMO; e = 1; end
            else begin
                w = b + SYNC + 2 + POST; if (w < ENDT) w = ENDT; e = 0;
            end
        end else begin
            w = ENDT; e = 0;
        end
        expd = e ? 16'h0 : (nb ? {8'h00, pat[7:0]} : pat);
        chk(fall_n == SETUP + 1, "R2 setup ticks", fall_n, SETUP + 1);
        chk(addr_ok, poke ? "R10 address held" : "R2 address stable", addr_ok, 1);
        chk(sel_ok, "R3 strobe select", sel_ok, 1);
        chk(ack_n - fall_n == w, e ? "R11 timeout width" :
            ((a >= 0 && a < WIN) ? "R5 stretched width" : "R4 strobe width"), ack_n - fall_n, w);
        chk(!strobe_at_ack && ack_cnt == 1, "R8 single ack at release", ack_cnt, 1);
        chk(got == expd, e ? "R11 data zero" : (nb ? "R7 narrow data" : "R6 capture data"),
            int'(got), int'(expd));
        chk(got_err == e, "R11 error flag", got_err, e);
        chk(!extra, "R10 no extra cycle", extra, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int fall2, ackn, n;
        repeat (3) @(negedge clk);
        chk(bus_memr_n && bus_ior_n, "R1 strobes idle", {bus_memr_n, bus_ior_n}, 3);
        chk(!ack && !err, "R1 ack/err low", {ack, err}, 0);
        chk(bus_addr == 0, "R1 address zero", int'(bus_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int a = -1; a <= 5; a++) begin
            for (int k = 1; k <= 6; k++) begin
                int b;
                b = (a < 0) ? -1 : a + k;
                run_cycle(20'h1_2000 + 20'(a * 64 + k), logic'((a + k) & 1),
                          logic'(k % 3 == 0), 16'hA5C3 ^ 16'(a * 37 + k * 1111),
                          a, b, 1'b0);
                if (a < 0) break;
            end
        end

        run_cycle(20'h0_0F0F, 1'b1, 1'b0, 16'h3C5A, 1, 1 + TMO, 1'b0);
        run_cycle(20'h0_F0F0, 1'b0, 1'b0, 16'h7E81, 1, 2 + TMO, 1'b0);
        run_cycle(20'hA_BCDE, 1'b0, 1'b1, 16'hBEEF, -1, -1, 1'b1);

        // R9: request held high across two cycles
        @(negedge clk);
        req_valid = 1'b1; req_addr = 20'h5_5555; req_io = 1'b0; req_byte = 1'b0;
        ackn = -1; fall2 = -1; n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (ack && ackn < 0) ackn = n;
            else if (ackn >= 0 && (!bus_memr_n || !bus_ior_n)) begin fall2 = n; break; end
        end
        req_valid = 1'b0;
        chk(fall2 - ackn == REC + 2 + SETUP, "R9 recovery gap", fall2 - ackn, REC + 2 + SETUP);
        repeat (20) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule